// File: doc/BRIEF.md
# Big-Endian Store Lane Unit

This block turns a single store instruction into one memory write request. It decodes the instruction word and keeps only the three store flavours: full word, halfword and single byte. It forms the effective address from a base register value and an optional signed 13-bit immediate. It then places the source register's low-order bits into the correct byte lanes of a 32-bit word, using big-endian ordering, and produces the matching byte-enable mask.

The caller presents the instruction, the base value and the source value together with a valid strobe. One clock later, one of two things appears. Either a write request (word address, steered data, enables) shows up, or a misalignment pulse does. A memory behind the block applies the enabled lanes and leaves the other lanes untouched. Loads, caches and the memory itself are handled elsewhere.

Top module: `store_lane_unit`

## Requirements
- R1: An instruction is a store only when bits 31:30 equal 11 and bits 24:19 hold one of the three store codes. Any other instruction, even with the valid strobe high, gives neither a write request nor a misalignment pulse.
- R2: The store codes in bits 24:19 are 000100 for a word store, 000110 for a halfword store and 000101 for a byte store.
- R3: When bit 13 is 1, the effective address is the base value plus bits 12:0 sign-extended to 32 bits. When bit 13 is 0, it is the base value alone. The word address output is effective address bits 31:2.
- R4: A word store at an address whose two low bits are 00 drives enables 1111 and write data equal to the source value.
- R5: A halfword store writes the source value's low 16 bits and drives all other data bits to zero. At byte offset 0 the data goes to data bits 31:16 with enables 1100. At byte offset 2 it goes to data bits 15:0 with enables 0011.
- R6: A byte store at byte offset k (0 to 3) drives enable bit 3-k only. It places the source value's low 8 bits at data bits 8*(3-k)+7 down to 8*(3-k), and all other data bits are zero.
- R7: A word store whose address bits 1:0 are not 00, or a halfword store whose address bit 0 is 1, raises the misalignment output for one cycle with no write request. The two outputs are never high together.
- R8: Outputs are registered with one cycle of latency. A new instruction is accepted on every cycle in which the valid strobe is high. In a cycle after one with the strobe low, both the write request and the misalignment output are low.
- R9: While reset is high, and in the first cycle after it, the write request and misalignment outputs are low.
- R10: A memory holding bytes in big-endian order, written through the enables, ends up with 0x12 at the lowest address after a word store of 0x12345678. Sub-word stores leave unenabled bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Base register value |
| src_val | input | 32 | Source register value to be stored |
| wr_valid | output | 1 | Write request issued |
| wr_addr | output | 30 | Word address of the write |
| wr_data | output | 32 | Lane-steered write data |
| wr_be | output | 4 | Byte enables, bit 3 is the lowest byte address |
| misalign | output | 1 | Misaligned store dropped |

## Verification
Address arithmetic and lane selection happen in the same cycle. The lane choice depends on the low bits of a sum that may borrow across a word boundary. The bench provokes this with negative immediates and with base values that end in odd offsets. It judges the enables, the data lanes and the word address together against a model built from the requirements. Misalignment detection and write steering also share a cycle. Misaligned and aligned stores are issued back to back, and every slot is checked to carry exactly the expected write or pulse.

// File: rtl/store_pkg.sv
package store_pkg;
  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_WORD = 2'd1,
    ST_HALF = 2'd2,
    ST_BYTE = 2'd3
  } st_kind_e;

  localparam logic [1:0] FMT_MEM  = 2'b11;
  localparam logic [5:0] OP3_WORD = 6'b000100;
  localparam logic [5:0] OP3_HALF = 6'b000110;
  localparam logic [5:0] OP3_BYTE = 6'b000101;
endpackage

// File: rtl/store_decode.sv
module store_decode
  import store_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int IMM_W   = 13
) (
  input  logic [INSTR_W-1:0] instr,
  output st_kind_e           kind,
  output logic               imm_sel,
  output logic [IMM_W-1:0]   simm
);
  localparam int FMT_HI = INSTR_W - 1;
  localparam int OP3_HI = 24;
  localparam int OP3_LO = 19;
  localparam int IBIT   = 13;

  logic [1:0] fmt;
  logic [5:0] op3;

  always_comb begin
    fmt     = instr[FMT_HI -: 2];
    op3     = instr[OP3_HI:OP3_LO];
    imm_sel = instr[IBIT];
    simm    = instr[IMM_W-1:0];
    kind    = ST_NONE;
    if (fmt == FMT_MEM) begin
      unique case (op3)
        OP3_WORD: kind = ST_WORD;
        OP3_HALF: kind = ST_HALF;
        OP3_BYTE: kind = ST_BYTE;
        default:  kind = ST_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic [ADDR_W-1:0] base_val,
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  simm,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = imm_sel ? {{EXT_W{simm[IMM_W-1]}}, simm} : '0;
    ea     = base_val + offset;
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import store_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  st_kind_e                        kind,
  input  logic [$clog2(DATA_W/8)-1:0]     off,
  input  logic [DATA_W-1:0]               src,
  output logic [DATA_W/8-1:0]             be,
  output logic [DATA_W-1:0]               data,
  output logic                            is_write,
  output logic                            mis
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  always_comb begin
    mis = 1'b0;
    unique case (kind)
      ST_WORD: mis = (off != '0);
      ST_HALF: mis = off[0];
      default: mis = 1'b0;
    endcase
    is_write = (kind != ST_NONE) && !mis;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [OFF_W-1:0] BO = OFF_W'(LANES - 1 - j);
    logic en;
    logic [7:0] byte_v;
    always_comb begin
      en     = 1'b0;
      byte_v = 8'h00;
      unique case (kind)
        ST_WORD: begin
          en     = 1'b1;
          byte_v = src[j*8 +: 8];
        end
        ST_HALF: begin
          en     = (BO[OFF_W-1:1] == off[OFF_W-1:1]);
          byte_v = BO[0] ? src[7:0] : src[15:8];
        end
        ST_BYTE: begin
          en     = (BO == off);
          byte_v = src[7:0];
        end
        default: begin
          en     = 1'b0;
          byte_v = 8'h00;
        end
      endcase
    end
    assign be[j]          = en && is_write;
    assign data[j*8 +: 8] = (en && is_write) ? byte_v : 8'h00;
  end
endmodule

// File: rtl/store_lane_unit.sv
module store_lane_unit
  import store_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 13,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WADR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic [DATA_W-1:0]  src_val,
  output logic               wr_valid,
  output logic [WADR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic [LANES-1:0]   wr_be,
  output logic               misalign
);
  st_kind_e          kind;
  logic              imm_sel;
  logic [IMM_W-1:0]  simm;
  logic [ADDR_W-1:0] ea;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] data_c;
  logic              write_c;
  logic              mis_c;

  store_decode #(.INSTR_W(INSTR_W), .IMM_W(IMM_W)) u_dec (
    .instr(instr), .kind(kind), .imm_sel(imm_sel), .simm(simm)
  );

  ea_adder #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_ea (
    .base_val(base_val), .imm_sel(imm_sel), .simm(simm), .ea(ea)
  );

  lane_steer #(.DATA_W(DATA_W)) u_steer (
    .kind(kind), .off(ea[OFF_W-1:0]), .src(src_val),
    .be(be_c), .data(data_c), .is_write(write_c), .mis(mis_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      misalign <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
    end else begin
      wr_valid <= in_valid && write_c;
      misalign <= in_valid && mis_c;
      wr_addr  <= ea[ADDR_W-1:OFF_W];
      wr_data  <= data_c;
      wr_be    <= be_c;
    end
  end

  logic [DATA_W-1:0] be_bits;
  for (genvar j = 0; j < LANES; j++) begin : g_mask
    assign be_bits[j*8 +: 8] = {8{wr_be[j]}};
  end

  assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && misalign));

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wr_valid && !misalign));

  assert_be_legal_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ($countones(wr_be) == 1 || $countones(wr_be) == 2 ||
                  $countones(wr_be) == LANES));

  assert_dead_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ((wr_data & ~be_bits) == '0));

  assert_no_be_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> (wr_be == '0 || !$past(in_valid)));
endmodule

// File: tb/test_store_lane_unit.sv
module test_store_lane_unit;
  localparam int PERIOD = 10;

  typedef struct {
    logic        wv;
    logic        mis;
    logic [29:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] base_val = '0;
  logic [31:0] src_val = '0;
  logic        wr_valid;
  logic [29:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        misalign;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  logic [7:0] dmem [0:127];
  logic [7:0] emem [0:127];

  always #(PERIOD/2) clk = ~clk;

  store_lane_unit i_store_lane_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .base_val(base_val), .src_val(src_val), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .misalign(misalign)
  );

  function automatic logic [31:0] mk(input logic [1:0] fmt, input logic [5:0] op3,
                                     input logic ib, input logic [12:0] imm);
    return {fmt, 5'd1, op3, 5'd2, ib, imm};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [31:0] b,
                       input logic [31:0] s, input string tag);
    exp_t e;
    logic [31:0] ea;
    logic [1:0] off;
    ea = ins[13] ? b + {{19{ins[12]}}, ins[12:0]} : b;
    off = ea[1:0];
    e.wv = 0; e.mis = 0; e.addr = ea[31:2]; e.data = '0; e.be = '0; e.tag = tag;
    if (ins[31:30] == 2'b11) begin
      case (ins[24:19])
        6'b000100: if (off != 0) e.mis = 1;
                   else begin e.wv = 1; e.be = 4'hF; e.data = s; end
        6'b000110: if (off[0]) e.mis = 1;
                   else if (off == 0) begin e.wv = 1; e.be = 4'hC; e.data = {s[15:0], 16'h0}; end
                   else begin e.wv = 1; e.be = 4'h3; e.data = {16'h0, s[15:0]}; end
        6'b000101: begin e.wv = 1; e.be = 4'h8 >> off; e.data = {s[7:0], 24'h0} >> (8 * off); end
        default: ;
      endcase
    end
    @(negedge clk);
    in_valid = 1'b1; instr = ins; base_val = b; src_val = s;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      instr = '0;
    end
  endtask

  initial begin : monitor
    forever begin
      logic took;
      exp_t e;
      @(posedge clk);
      took = in_valid && !rst && q.size() > 0;
      if (took) e = q.pop_front();
      #(PERIOD/4);
      if (rst) continue;
      if (took) begin
        check(wr_valid == e.wv, e.tag, "wr_valid", 64'(wr_valid), 64'(e.wv));
        check(misalign == e.mis, "R7", {e.tag, " misalign"}, 64'(misalign), 64'(e.mis));
        if (e.wv) begin
          check(wr_be == e.be, e.tag, "wr_be", 64'(wr_be), 64'(e.be));
          check(wr_data == e.data, e.tag, "wr_data", 64'(wr_data), 64'(e.data));
          check(wr_addr == e.addr, "R3", {e.tag, " wr_addr"}, 64'(wr_addr), 64'(e.addr));
          for (int k = 0; k < 4; k++)
            if (wr_be[3-k]) dmem[{wr_addr[4:0], 2'(k)}] = wr_data[8*(3-k) +: 8];
        end
      end else begin
        check(!wr_valid && !misalign, "R8", "idle slot",
              64'({wr_valid, misalign}), 64'(0));
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < 128; i++) begin dmem[i] = 8'h20; emem[i] = 8'h20; end
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    check(!wr_valid && !misalign, "R9", "during reset", 64'({wr_valid, misalign}), 64'(0));
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #(PERIOD/4);
    check(!wr_valid && !misalign, "R9", "first cycle after reset",
          64'({wr_valid, misalign}), 64'(0));

    // R10 / R4 / R5 / R6: big-endian image build, back to back
    issue(mk(2'b11, 6'b000100, 1, 13'd72), 32'h0, 32'h12345678, "R4 word 72");
    issue(mk(2'b11, 6'b000110, 1, 13'd76), 32'h0, 32'h12345678, "R5 half off0");
    issue(mk(2'b11, 6'b000110, 1, 13'd82), 32'h0, 32'h12345678, "R5 half off2");
    issue(mk(2'b11, 6'b000101, 1, 13'd84), 32'h0, 32'h12345678, "R6 byte off0");
    issue(mk(2'b11, 6'b000101, 1, 13'd89), 32'h0, 32'h12345678, "R6 byte off1");
    issue(mk(2'b11, 6'b000101, 1, 13'd94), 32'h0, 32'h12345678, "R6 byte off2");
    issue(mk(2'b11, 6'b000101, 1, 13'd99), 32'h0, 32'h12345678, "R6 byte off3");
    idle(2);
    // R7 misaligned mixed with aligned
    issue(mk(2'b11, 6'b000100, 1, 13'd2), 32'h1000, 32'hDEADBEEF, "R7 word off2");
    issue(mk(2'b11, 6'b000100, 1, 13'd0), 32'h1000, 32'hCAFEF00D, "R4 word after mis");
    issue(mk(2'b11, 6'b000110, 1, 13'd1), 32'h1000, 32'hAAAA5555, "R7 half off1");
    issue(mk(2'b11, 6'b000110, 1, 13'd3), 32'h1000, 32'hAAAA5555, "R7 half off3");
    issue(mk(2'b11, 6'b000100, 1, 13'd1), 32'h1000, 32'h1, "R7 word off1");
    // R3 negative offsets, extremes, immediate bit clear
    issue(mk(2'b11, 6'b000101, 1, 13'h1FFF), 32'h100, 32'h000000AB, "R3 R6 imm -1");
    issue(mk(2'b11, 6'b000100, 1, 13'h1000), 32'h2000, 32'h01020304, "R3 R4 imm min");
    issue(mk(2'b11, 6'b000110, 1, 13'h0FFE), 32'h0, 32'hFFFF1234, "R3 R5 imm max-1");
    issue(mk(2'b11, 6'b000101, 0, 13'h0007), 32'h203, 32'h0000005A, "R3 R6 imm off");
    issue(mk(2'b11, 6'b000100, 1, 13'h1FFC), 32'h0, 32'h77, "R3 R4 wrap");
    // R1 / R2 non-stores
    issue(mk(2'b10, 6'b000100, 1, 13'd0), 32'h0, 32'h1, "R1 fmt 10");
    issue(mk(2'b11, 6'b000000, 1, 13'd1), 32'h0, 32'h1, "R2 op3 other");
    issue(mk(2'b11, 6'b000111, 1, 13'd2), 32'h0, 32'h1, "R2 op3 near");
    issue(mk(2'b01, 6'b000101, 1, 13'd3), 32'h0, 32'h1, "R1 fmt 01");
    idle(4);

    emem[72] = 8'h12; emem[73] = 8'h34; emem[74] = 8'h56; emem[75] = 8'h78;
    emem[76] = 8'h56; emem[77] = 8'h78; emem[82] = 8'h56; emem[83] = 8'h78;
    emem[84] = 8'h78; emem[89] = 8'h78; emem[94] = 8'h78; emem[99] = 8'h78;
    for (int a = 72; a < 104; a++)
      check(dmem[a] == emem[a], "R10", $sformatf("mem byte %0d", a),
            64'(dmem[a]), 64'(emem[a]));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule